// File: doc/BRIEF.md
# Presence-Flagged Ring Channel Buffer

This block sits between a memory fetch engine and a consumer and gives the consumer a single head word whose availability is shown by a presence flag. The fetch side claims slots in request order; each claim hands back a slot tag. Returned data may come back in any order and is steered into its claimed slot by that tag. The consumer only ever sees the head slot, and it stalls until that slot's data has arrived.

The consumer works the head through a small op code. It can peek at the word, take it (freeing the slot and moving on), replace it in place, or push a new word in front of it. A fetched word can carry an end-of-record mark, which the consumer sees as a separate flag, never as data. A slot claimed with the loop flag turns the buffer into a replay ring. A clear flushes everything so a new channel program can start.

Top module: `chan_ring`

## Requirements
- R1: After reset and on the cycle after `clear_i`, the head is empty (`head_valid_o`=0, `head_eor_o`=0), `full_o`=0, `loop_o`=0 and `alloc_tag_o`=0. A clear drops all contents and overrides every other input in that cycle.
- R2: Each accepted claim (`alloc_req_i` with `alloc_rdy_o`=1) is given the slot named by `alloc_tag_o`. The tag then advances by one, wrapping from DEPTH-1 to 0.
- R3: `full_o` is 1 when DEPTH slots are claimed and not yet taken. While full, `alloc_rdy_o`=0 and a claim is refused without moving the tag.
- R4: Returned data (`fill_valid_i`, `fill_tag_i`) is written into its claimed slot in whatever order it arrives. Words reach the head in claim order. `head_valid_o` stays 0 until the head slot's data is present.
- R5: A return whose tag names a slot that is not currently claimed is dropped. It does not show up later when that slot is claimed.
- R6: Peek (`op_i`=1) on a valid head leaves the head word, its presence and the slot order unchanged.
- R7: Take (`op_i`=2) on a valid head clears that slot's presence, frees it, and moves the head to the next slot. The next slot becomes visible once its data is present.
- R8: Replace (`op_i`=3) writes `st_data_i` over the head slot, marks it present and clears its end-of-record mark. It is refused when the head slot is not claimed.
- R9: Push (`op_i`=4) places `st_data_i` in the slot before the head and makes it the new present head, so the old head is next in line. It is refused when full, when the same-cycle claim would fill the last slot, or in loop mode.
- R10: A claim with `alloc_loop_i`=1 enters loop mode. The loop body runs from the head slot of that cycle through the flagged slot. In loop mode a take keeps the data and presence, and after the flagged slot the head returns to the first body slot, until a clear. `loop_o` shows the mode, and no claims or pushes are accepted while it is set.
- R11: A word returned with `fill_eor_i`=1 is shown at the head as `head_eor_o`=1 with `head_valid_o`=0. A take on it is refused and the mark stays.
- R12: `op_ack_o` is 1 in exactly the cycle an op is accepted. That is a peek or take on a valid head, a replace on a claimed head, or a push that has room. It is 0 for op 0 and whenever `clear_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clear_i | input | 1 | Flush all slots, pointers and loop mode |
| alloc_req_i | input | 1 | Fetch side requests a slot |
| alloc_loop_i | input | 1 | Requested slot closes a loop body |
| alloc_rdy_o | output | 1 | A claim would be accepted this cycle |
| alloc_tag_o | output | PTR_W (3) | Slot given to the next accepted claim |
| full_o | output | 1 | All slots claimed |
| fill_valid_i | input | 1 | Returned data is valid |
| fill_tag_i | input | PTR_W (3) | Slot the returned data belongs to |
| fill_data_i | input | DATA_W (32) | Returned data word |
| fill_eor_i | input | 1 | Returned word is an end-of-record mark |
| op_i | input | 3 | Consumer op: 0 none, 1 peek, 2 take, 3 replace, 4 push |
| st_data_i | input | DATA_W (32) | Word for replace and push |
| op_ack_o | output | 1 | Op accepted this cycle |
| head_valid_o | output | 1 | Head holds present data |
| head_eor_o | output | 1 | Head holds an end-of-record mark |
| head_data_o | output | DATA_W (32) | Head word |
| loop_o | output | 1 | Loop mode active |

## Verification
The bench builds the block at its defaults, eight slots of 32 bits. With 3-bit tags, random returns touch every slot, wrap the claim and head pointers many times, and reach the full state within eight claims. The small depth also lets a three-slot loop body wrap back several times in a short run. Random claims, out-of-order returns, ops, loop entries and clears are compared every cycle against a bench model. Directed runs cover wrong-tag returns, ops on an empty head, end-of-record handling and loop replay.

// File: rtl/chan_ring_pkg.sv
package chan_ring_pkg;
  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_PEEK    = 3'd1,
    OP_TAKE    = 3'd2,
    OP_REPLACE = 3'd3,
    OP_PUSH    = 3'd4
  } ring_op_e;
endpackage

// File: rtl/chan_ring_rst_sync.sv
module chan_ring_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/chan_ring_ctrl.sv
module chan_ring_ctrl
  import chan_ring_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             alloc_req_i,
  input  logic             alloc_loop_i,
  input  logic [2:0]       op_i,
  input  logic             head_present_i,
  input  logic             head_eor_i,
  input  logic             head_busy_i,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] push_slot_o,
  output logic             alloc_fire_o,
  output logic             take_fire_o,
  output logic             keep_o,
  output logic             repl_fire_o,
  output logic             push_fire_o,
  output logic             op_ack_o,
  output logic             alloc_rdy_o,
  output logic             full_o,
  output logic             loop_o,
  output logic [CNT_W-1:0] count_o
);
  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH - 1) : p - 1'b1;
  endfunction

  ring_op_e op;
  assign op = ring_op_e'(op_i);

  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d, lfirst_q, lfirst_d, llast_q, llast_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             loop_q, loop_d;
  logic             head_ok, full, alloc_rdy, alloc_fire, take_fire, repl_fire, push_fire, peek_ok;
  logic [CNT_W:0]   used;
  logic             upd_en;

  assign head_ok    = head_present_i & ~head_eor_i;
  assign full       = (count_q == CNT_W'(DEPTH));
  assign alloc_rdy  = ~full & ~loop_q;
  assign alloc_fire = alloc_req_i & alloc_rdy & ~clear_i;
  assign peek_ok    = (op == OP_PEEK) & head_ok & ~clear_i;
  assign take_fire  = (op == OP_TAKE) & head_ok & ~clear_i;
  assign repl_fire  = (op == OP_REPLACE) & head_busy_i & ~clear_i;
  assign used       = {1'b0, count_q} + (CNT_W + 1)'(alloc_fire);
  assign push_fire  = (op == OP_PUSH) & ~loop_q & (used < (CNT_W + 1)'(DEPTH)) & ~clear_i;
  assign upd_en     = clear_i | alloc_fire | take_fire | push_fire;

  always_comb begin
    rd_d     = rd_q;
    wr_d     = wr_q;
    count_d  = count_q;
    loop_d   = loop_q;
    lfirst_d = lfirst_q;
    llast_d  = llast_q;
    if (clear_i) begin
      rd_d    = '0;
      wr_d    = '0;
      count_d = '0;
      loop_d  = 1'b0;
    end else begin
      if (push_fire)
        rd_d = ptr_dec(rd_q);
      else if (take_fire)
        rd_d = (loop_q && rd_q == llast_q) ? lfirst_q : ptr_inc(rd_q);
      if (alloc_fire) wr_d = ptr_inc(wr_q);
      count_d = count_q + CNT_W'(alloc_fire) + CNT_W'(push_fire)
              - CNT_W'(take_fire & ~loop_q);
      if (alloc_fire && alloc_loop_i) begin
        loop_d   = 1'b1;
        llast_d  = wr_q;
        lfirst_d = rd_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q     <= '0;
      wr_q     <= '0;
      count_q  <= '0;
      loop_q   <= 1'b0;
      lfirst_q <= '0;
      llast_q  <= '0;
    end else if (upd_en) begin
      rd_q     <= rd_d;
      wr_q     <= wr_d;
      count_q  <= count_d;
      loop_q   <= loop_d;
      lfirst_q <= lfirst_d;
      llast_q  <= llast_d;
    end
  end

  assign rd_ptr_o     = rd_q;
  assign wr_ptr_o     = wr_q;
  assign push_slot_o  = ptr_dec(rd_q);
  assign alloc_fire_o = alloc_fire;
  assign take_fire_o  = take_fire;
  assign keep_o       = loop_q;
  assign repl_fire_o  = repl_fire;
  assign push_fire_o  = push_fire;
  assign op_ack_o     = peek_ok | take_fire | repl_fire | push_fire;
  assign alloc_rdy_o  = alloc_rdy;
  assign full_o       = full;
  assign loop_o       = loop_q;
  assign count_o      = count_q;
endmodule

// File: rtl/chan_ring_slots.sv
module chan_ring_slots #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              fill_valid_i,
  input  logic [PTR_W-1:0]  fill_tag_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              fill_eor_i,
  input  logic              alloc_fire_i,
  input  logic [PTR_W-1:0]  wr_ptr_i,
  input  logic              take_fire_i,
  input  logic              keep_i,
  input  logic [PTR_W-1:0]  rd_ptr_i,
  input  logic              repl_fire_i,
  input  logic              push_fire_i,
  input  logic [PTR_W-1:0]  push_slot_i,
  input  logic [DATA_W-1:0] st_data_i,
  output logic              head_present_o,
  output logic              head_eor_o,
  output logic              head_busy_o,
  output logic [DATA_W-1:0] head_data_o,
  output logic [DEPTH-1:0]  busy_o
);
  logic [DEPTH-1:0]  busy_w, pres_w, eor_w;
  logic [DATA_W-1:0] data_w [DEPTH];
  logic              fill_ok;

  assign fill_ok = fill_valid_i & busy_w[fill_tag_i] & ~clear_i;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic              busy_q, busy_d, pres_q, pres_d, eor_q, eor_d, we, flag_en;
    logic [DATA_W-1:0] data_q, data_d;
    logic              alloc_hit, fill_hit, head_hit, push_hit, st_hit, drop_hit;

    assign alloc_hit = alloc_fire_i & (wr_ptr_i == PTR_W'(g));
    assign fill_hit  = fill_ok & (fill_tag_i == PTR_W'(g));
    assign head_hit  = (rd_ptr_i == PTR_W'(g));
    assign push_hit  = push_fire_i & (push_slot_i == PTR_W'(g));
    assign st_hit    = (repl_fire_i & head_hit) | push_hit;
    assign drop_hit  = take_fire_i & ~keep_i & head_hit;
    assign flag_en   = clear_i | alloc_hit | fill_hit | st_hit | drop_hit;

    always_comb begin
      busy_d = busy_q;
      pres_d = pres_q;
      eor_d  = eor_q;
      data_d = data_q;
      we     = 1'b0;
      if (clear_i) begin
        busy_d = 1'b0;
        pres_d = 1'b0;
        eor_d  = 1'b0;
      end else begin
        if (alloc_hit) busy_d = 1'b1;
        if (fill_hit) begin
          pres_d = 1'b1;
          eor_d  = fill_eor_i;
          data_d = fill_data_i;
          we     = 1'b1;
        end
        if (st_hit) begin
          pres_d = 1'b1;
          eor_d  = 1'b0;
          data_d = st_data_i;
          we     = 1'b1;
        end
        if (push_hit) busy_d = 1'b1;
        if (drop_hit) begin
          busy_d = 1'b0;
          pres_d = 1'b0;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q <= 1'b0;
        pres_q <= 1'b0;
        eor_q  <= 1'b0;
      end else if (flag_en) begin
        busy_q <= busy_d;
        pres_q <= pres_d;
        eor_q  <= eor_d;
      end
    end

    always_ff @(posedge clk) begin
      if (we) data_q <= data_d;
    end

    assign busy_w[g] = busy_q;
    assign pres_w[g] = pres_q;
    assign eor_w[g]  = eor_q;
    assign data_w[g] = data_q;
  end

  assign head_present_o = pres_w[rd_ptr_i];
  assign head_eor_o     = eor_w[rd_ptr_i];
  assign head_busy_o    = busy_w[rd_ptr_i];
  assign head_data_o    = data_w[rd_ptr_i];
  assign busy_o         = busy_w;
endmodule

// File: rtl/chan_ring.sv
module chan_ring #(
  parameter  int DEPTH  = 8,
  parameter  int DATA_W = 32,
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              alloc_req_i,
  input  logic              alloc_loop_i,
  output logic              alloc_rdy_o,
  output logic [PTR_W-1:0]  alloc_tag_o,
  output logic              full_o,
  input  logic              fill_valid_i,
  input  logic [PTR_W-1:0]  fill_tag_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              fill_eor_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] st_data_i,
  output logic              op_ack_o,
  output logic              head_valid_o,
  output logic              head_eor_o,
  output logic [DATA_W-1:0] head_data_o,
  output logic              loop_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             rst_int_n;
  logic [PTR_W-1:0] rd_ptr, wr_ptr, push_slot;
  logic             alloc_fire, take_fire, keep, repl_fire, push_fire;
  logic             head_present, head_eor, head_busy;
  logic [CNT_W-1:0] count_w;
  logic [DEPTH-1:0] busy_w;

  chan_ring_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_int_n)
  );

  chan_ring_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .clear_i        (clear_i),
    .alloc_req_i    (alloc_req_i),
    .alloc_loop_i   (alloc_loop_i),
    .op_i           (op_i),
    .head_present_i (head_present),
    .head_eor_i     (head_eor),
    .head_busy_i    (head_busy),
    .rd_ptr_o       (rd_ptr),
    .wr_ptr_o       (wr_ptr),
    .push_slot_o    (push_slot),
    .alloc_fire_o   (alloc_fire),
    .take_fire_o    (take_fire),
    .keep_o         (keep),
    .repl_fire_o    (repl_fire),
    .push_fire_o    (push_fire),
    .op_ack_o       (op_ack_o),
    .alloc_rdy_o    (alloc_rdy_o),
    .full_o         (full_o),
    .loop_o         (loop_o),
    .count_o        (count_w)
  );

  chan_ring_slots #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_slots (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .clear_i        (clear_i),
    .fill_valid_i   (fill_valid_i),
    .fill_tag_i     (fill_tag_i),
    .fill_data_i    (fill_data_i),
    .fill_eor_i     (fill_eor_i),
    .alloc_fire_i   (alloc_fire),
    .wr_ptr_i       (wr_ptr),
    .take_fire_i    (take_fire),
    .keep_i         (keep),
    .rd_ptr_i       (rd_ptr),
    .repl_fire_i    (repl_fire),
    .push_fire_i    (push_fire),
    .push_slot_i    (push_slot),
    .st_data_i      (st_data_i),
    .head_present_o (head_present),
    .head_eor_o     (head_eor),
    .head_busy_o    (head_busy),
    .head_data_o    (head_data_o),
    .busy_o         (busy_w)
  );

  assign alloc_tag_o  = wr_ptr;
  assign head_valid_o = head_present & ~head_eor;
  assign head_eor_o   = head_present & head_eor;
endmodule

// File: rtl/chan_ring_chk.sv
module chan_ring_chk #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int PTR_W  = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear_i,
  input logic              alloc_req_i,
  input logic              alloc_rdy_o,
  input logic [PTR_W-1:0]  alloc_tag_o,
  input logic              full_o,
  input logic              fill_valid_i,
  input logic [2:0]        op_i,
  input logic              op_ack_o,
  input logic              head_valid_o,
  input logic              head_eor_o,
  input logic [DATA_W-1:0] head_data_o,
  input logic              loop_o,
  input logic [CNT_W-1:0]  count_w,
  input logic [DEPTH-1:0]  busy_w
);
  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  p_clear_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!head_valid_o && !head_eor_o && !full_o && !loop_o && alloc_tag_o == '0));

  p_tag_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req_i && alloc_rdy_o && !clear_i) |=> (alloc_tag_o == nxt($past(alloc_tag_o))));

  p_tag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req_i && !alloc_rdy_o && !clear_i) |=> $stable(alloc_tag_o));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !alloc_rdy_o);

  p_claim_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count_w) == $countones(busy_w));

  p_peek_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd1 && op_ack_o && !fill_valid_i && !clear_i) |=> (head_valid_o && $stable(head_data_o)));

  p_push_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && op_i == 3'd4) |-> !op_ack_o);

  p_loop_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    loop_o |-> !alloc_rdy_o);

  p_eor_hidden_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(head_valid_o && head_eor_o));

  p_eor_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (head_eor_o && op_i == 3'd2) |-> !op_ack_o);

  p_clear_noack_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |-> !op_ack_o);
endmodule

bind chan_ring chan_ring_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .clear_i      (clear_i),
  .alloc_req_i  (alloc_req_i),
  .alloc_rdy_o  (alloc_rdy_o),
  .alloc_tag_o  (alloc_tag_o),
  .full_o       (full_o),
  .fill_valid_i (fill_valid_i),
  .op_i         (op_i),
  .op_ack_o     (op_ack_o),
  .head_valid_o (head_valid_o),
  .head_eor_o   (head_eor_o),
  .head_data_o  (head_data_o),
  .loop_o       (loop_o),
  .count_w      (count_w),
  .busy_w       (busy_w)
);

// File: tb/chan_ring_bench.sv
module chan_ring_bench;
  localparam int DEPTH = 8;
  localparam int DW    = 32;

  logic          clk = 1'b0;
  logic          rst_n, clear, alloc_req, alloc_loop, fill_valid, fill_eor;
  logic [2:0]    fill_tag, op;
  logic [DW-1:0] fill_data, st_data;
  logic          alloc_rdy, full, op_ack, head_valid, head_eor, loop_o;
  logic [2:0]    alloc_tag;
  logic [DW-1:0] head_data;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 1'b0;

  bit          m_pres [DEPTH];
  bit          m_busy [DEPTH];
  bit          m_eor  [DEPTH];
  logic [31:0] m_data [DEPTH];
  int          m_rd, m_wr, m_cnt, m_lf, m_ll;
  bit          m_loop;

  always #5 clk = ~clk;

  chan_ring u_chan_ring (
    .clk(clk), .rst_n(rst_n), .clear_i(clear),
    .alloc_req_i(alloc_req), .alloc_loop_i(alloc_loop),
    .alloc_rdy_o(alloc_rdy), .alloc_tag_o(alloc_tag), .full_o(full),
    .fill_valid_i(fill_valid), .fill_tag_i(fill_tag), .fill_data_i(fill_data),
    .fill_eor_i(fill_eor), .op_i(op), .st_data_i(st_data), .op_ack_o(op_ack),
    .head_valid_o(head_valid), .head_eor_o(head_eor), .head_data_o(head_data),
    .loop_o(loop_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < DEPTH; i++) begin
      m_pres[i] = 0; m_busy[i] = 0; m_eor[i] = 0;
    end
    m_rd = 0; m_wr = 0; m_cnt = 0; m_loop = 0;
  endtask

  task automatic cyc(input bit a, input bit al, input bit fv, input int ft,
                     input logic [31:0] fd, input bit fe, input int o,
                     input logic [31:0] sd, input bit clr);
    bit hok, fok, a_f, t_f, r_f, p_f, ack;
    int s;
    @(negedge clk);
    alloc_req = a; alloc_loop = al; fill_valid = fv; fill_tag = 3'(ft);
    fill_data = fd; fill_eor = fe; op = 3'(o); st_data = sd; clear = clr;
    #1;
    hok = m_pres[m_rd] && !m_eor[m_rd];
    check("R4 head valid", head_valid, hok);
    check("R11 head eor", head_eor, m_pres[m_rd] && m_eor[m_rd]);
    if (hok) check("R4 head data", head_data, m_data[m_rd]);
    check("R3 full", full, m_cnt == DEPTH);
    check("R3 alloc ready", alloc_rdy, m_cnt != DEPTH && !m_loop);
    check("R2 alloc tag", alloc_tag, m_wr);
    check("R10 loop flag", loop_o, m_loop);
    fok = fv && m_busy[ft];
    a_f = a && m_cnt != DEPTH && !m_loop;
    t_f = (o == 2) && hok;
    r_f = (o == 3) && m_busy[m_rd];
    p_f = (o == 4) && !m_loop && (m_cnt + int'(a_f)) < DEPTH;
    ack = ((o == 1) && hok) || t_f || r_f || p_f;
    if (clr) ack = 0;
    check("R12 op ack", op_ack, ack);
    if (clr) model_clear();
    else begin
      if (fok) begin m_data[ft] = fd; m_eor[ft] = fe; m_pres[ft] = 1; end
      if (r_f) begin m_data[m_rd] = sd; m_eor[m_rd] = 0; m_pres[m_rd] = 1; end
      if (p_f) begin
        s = (m_rd + DEPTH - 1) % DEPTH;
        m_data[s] = sd; m_eor[s] = 0; m_pres[s] = 1; m_busy[s] = 1;
        m_rd = s; m_cnt++;
      end
      if (t_f) begin
        if (m_loop) m_rd = (m_rd == m_ll) ? m_lf : (m_rd + 1) % DEPTH;
        else begin
          m_pres[m_rd] = 0; m_busy[m_rd] = 0;
          m_rd = (m_rd + 1) % DEPTH; m_cnt--;
        end
      end
      if (a_f) begin
        m_busy[m_wr] = 1;
        if (al) begin m_loop = 1; m_ll = m_wr; m_lf = m_rd; end
        m_wr = (m_wr + 1) % DEPTH; m_cnt++;
      end
    end
    @(posedge clk);
    #1;
  endtask

  task automatic claim(input bit lp);        cyc(1, lp, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic ret(input int t, input logic [31:0] d, input bit e); cyc(0, 0, 1, t, d, e, 0, 0, 0); endtask
  task automatic do_op(input int o, input logic [31:0] sd); cyc(0, 0, 0, 0, 0, 0, o, sd, 0); endtask
  task automatic flush();                    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 0; clear = 0; alloc_req = 0; alloc_loop = 0; fill_valid = 0;
    fill_tag = 0; fill_data = 0; fill_eor = 0; op = 0; st_data = 0;
    model_clear();
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 reset head valid", head_valid, 0);
    check("R1 reset head eor", head_eor, 0);
    check("R1 reset full", full, 0);
    check("R1 reset tag", alloc_tag, 0);
    check("R1 reset loop", loop_o, 0);

    // R4: out-of-order returns, claim-order delivery
    claim(0); claim(0); claim(0);
    ret(2, 32'hC2, 0); ret(1, 32'hC1, 0);
    check("R4 head waits for slot 0", head_valid, 0);
    ret(0, 32'hC0, 0);
    check("R4 first word", head_data, 32'hC0);
    do_op(2, 0);
    check("R7 take advances", head_data, 32'hC1);
    do_op(2, 0); do_op(2, 0);
    check("R7 drained", head_valid, 0);

    // R6 peek
    claim(0); ret(3, 32'h66, 0);
    do_op(1, 0); do_op(1, 0);
    check("R6 peek keeps valid", head_valid, 1);
    check("R6 peek keeps data", head_data, 32'h66);

    // R8 replace
    do_op(3, 32'h88);
    check("R8 replace data", head_data, 32'h88);
    do_op(2, 0);
    do_op(3, 32'h99);
    check("R8 replace on free head ignored", head_valid, 0);

    // R5 return to unclaimed slot
    ret(4, 32'h55, 0);
    check("R5 stray return ignored", head_valid, 0);
    claim(0);
    check("R5 stray return not kept", head_valid, 0);

    // R9 push
    ret(4, 32'h44, 0);
    do_op(4, 32'h91);
    check("R9 pushed word at head", head_data, 32'h91);
    do_op(2, 0);
    check("R9 old head follows", head_data, 32'h44);

    // R3 full
    flush();
    check("R1 clear tag", alloc_tag, 0);
    for (int i = 0; i < DEPTH; i++) claim(0);
    check("R3 full after eight", full, 1);
    claim(0);
    check("R3 refused claim keeps tag", alloc_tag, 0);
    do_op(4, 32'h1);
    check("R9 push refused when full", head_valid, 0);

    // R11 end-of-record
    flush();
    claim(0); claim(0);
    ret(0, 32'hE0, 1); ret(1, 32'h11, 0);
    check("R11 eor flagged", head_eor, 1);
    check("R11 eor not data", head_valid, 0);
    do_op(2, 0);
    check("R11 take on eor refused", head_eor, 1);
    do_op(3, 32'h12);
    check("R8 replace clears eor", head_data, 32'h12);

    // R10 loop replay
    flush();
    claim(0); claim(0); claim(1);
    ret(0, 32'hA0, 0); ret(1, 32'hA1, 0); ret(2, 32'hA2, 0);
    check("R10 loop entered", loop_o, 1);
    check("R10 no claims in loop", alloc_rdy, 0);
    do_op(2, 0); check("R10 step 1", head_data, 32'hA1);
    do_op(2, 0); check("R10 step 2", head_data, 32'hA2);
    do_op(2, 0); check("R10 wraps to first", head_data, 32'hA0);
    do_op(2, 0); check("R10 second pass", head_data, 32'hA1);
    flush();
    check("R1 clear ends loop", loop_o, 0);
    check("R1 clear empties head", head_valid, 0);

    // random mix
    for (int k = 0; k < 4000; k++) begin
      cyc(bit'($urandom % 2), ($urandom % 50) == 0, ($urandom % 3) != 0,
          int'($urandom % DEPTH), $urandom, ($urandom % 16) == 0,
          int'($urandom % 5), $urandom, ($urandom % 80) == 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule